// File: doc/BRIEF.md
# Predicate compare and writeback unit

This block evaluates one integer test per cycle and folds its one-bit outcome into a 64-entry predicate register file as a pair of target predicates. The test is a relation between two 64-bit operands, or between the low 32 bits of each. It can also be a probe of one bit of an operand, or a probe of a deferred-exception flag that travels with an operand. The second operand comes either from a register source or from an immediate input.

A compare-type select sets how the outcome and the qualifying predicate are turned into writes. The target may be written, forced to 0, forced to 1 or left alone. This lets branch-free code build conjunctions and disjunctions of conditions directly in predicates.

The whole predicate file is visible on an output vector. Updates land on the clock edge that samples the valid strobe. When both target indices name the same entry, the first target wins and a flag pulses.

Top module: `pred_cmp_unit`

## Requirements
- R1: After reset every predicate reads 0 except entry 0, and `conflict_o` is 0.
- R2: With `op_i`=0 (compare), `rel_i` selects eq=0, ne=1, lt=2, le=3, gt=4, ge=5 (signed, two's complement) and ltu=6, leu=7, gtu=8, geu=9 (unsigned). Codes 10 to 15 give a false outcome.
- R3: With `narrow_i`=1 only bits 31:0 of each operand take part, and bit 31 is the sign for signed relations. The upper 32 bits have no effect.
- R4: With `use_imm_i`=1 the second operand is `imm_i` and `src_b_i` is ignored.
- R5: `ctype_i`=0 (normal): when the qualifying predicate is 1, the first target gets the outcome and the second its complement. Otherwise both are unchanged.
- R6: `ctype_i`=1 (unconditional): same as normal when the qualifying predicate is 1, and both targets become 0 when it is 0.
- R7: `ctype_i`=2 clears both targets when the qualifying predicate is 1 and the outcome is 0. `ctype_i`=3 clears both when the qualifying predicate is 1 and the outcome is 1. In all other cases the targets are unchanged.
- R8: `ctype_i`=4 sets both targets when the qualifying predicate is 1 and the outcome is 1. `ctype_i`=5 sets both when the qualifying predicate is 1 and the outcome is 0.
- R9: `ctype_i`=6 sets the first target and clears the second when the qualifying predicate is 1 and the outcome is 1. `ctype_i`=7 clears the first and sets the second when the qualifying predicate is 1 and the outcome is 0.
- R10: `op_i`=1 takes the outcome from bit `bit_pos_i` of `src_a_i`. `op_i`=2 takes it from `nat_i`. Both write the targets exactly as a compare does.
- R11: Predicate 0 always reads 1, and writes to it are dropped. It therefore serves as an always-true qualifier.
- R12: When both targets are written and name the same entry, the first target's value is stored and `conflict_o` is 1 for the following cycle. Otherwise `conflict_o` is 0.
- R13: Writes take effect on the rising edge at which `valid_i` is 1 and are not visible before it. With `valid_i`=0 the file does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | 0 compare, 1 bit probe, 2 flag probe |
| rel_i | input | 4 | Relation select |
| narrow_i | input | 1 | 1 selects the 32-bit compare |
| ctype_i | input | 3 | Compare type |
| src_a_i | input | 64 | First operand |
| src_b_i | input | 64 | Second operand, register form |
| use_imm_i | input | 1 | Take the second operand from imm_i |
| imm_i | input | 64 | Immediate second operand |
| bit_pos_i | input | 6 | Bit index for the bit probe |
| nat_i | input | 1 | Deferred-exception flag of the probed operand |
| qp_idx_i | input | 6 | Qualifying predicate index |
| t1_idx_i | input | 6 | First target index |
| t2_idx_i | input | 6 | Second target index |
| pred_o | output | 64 | Predicate file contents, bit n is entry n |
| conflict_o | output | 1 | Both targets hit the same entry on the last write |

## Verification
The bench drives operands that differ only in sign or only in their upper half. A design that mixes up signed and unsigned order, or that lets the high word leak into the narrow compare, gives the wrong predicate pair. Each compare type is run with the outcome both true and false, on targets preset to the opposite value. This exposes a type that writes when it should hold, or that holds when it should write. A false qualifying predicate, writes aimed at entry 0, equal target indices, and a valid strobe observed before its clock edge are also run. These catch a design that clobbers the constant entry, lets the second target win, or updates without the strobe.

// File: rtl/pred_cmp_pkg.sv
package pred_cmp_pkg;
  typedef enum logic [1:0] {
    OP_CMP  = 2'd0,
    OP_TBIT = 2'd1,
    OP_TNAT = 2'd2,
    OP_NONE = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    REL_EQ  = 4'd0, REL_NE  = 4'd1,
    REL_LT  = 4'd2, REL_LE  = 4'd3, REL_GT  = 4'd4, REL_GE  = 4'd5,
    REL_LTU = 4'd6, REL_LEU = 4'd7, REL_GTU = 4'd8, REL_GEU = 4'd9
  } rel_e;

  typedef enum logic [2:0] {
    CT_NORM     = 3'd0,
    CT_UNC      = 3'd1,
    CT_AND      = 3'd2,
    CT_ANDCM    = 3'd3,
    CT_OR       = 3'd4,
    CT_ORCM     = 3'd5,
    CT_OR_ANDCM = 3'd6,
    CT_AND_ORCM = 3'd7
  } ctype_e;

  typedef struct packed {
    logic we1;
    logic v1;
    logic we2;
    logic v2;
  } pwr_t;
endpackage

// File: rtl/pred_cmp_eval.sv
module pred_cmp_eval
  import pred_cmp_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  localparam int POS_W   = $clog2(DATA_W)
) (
  input  logic [1:0]        op_i,
  input  logic [3:0]        rel_i,
  input  logic              narrow_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [POS_W-1:0]  bit_pos_i,
  input  logic              nat_i,
  output logic              res_o
);
  localparam int HI_W = DATA_W - NARROW_W;

  logic              sgn_rel;
  logic [DATA_W-1:0] a_x, b_x;
  logic              eq, lts, ltu, cmp_res;

  always_comb begin
    sgn_rel = (rel_i >= REL_LT) && (rel_i <= REL_GE);
    // narrow form: rebuild upper bits from bit NARROW_W-1 (signed) or zero
    if (narrow_i) begin
      a_x = {{HI_W{sgn_rel & a_i[NARROW_W-1]}}, a_i[NARROW_W-1:0]};
      b_x = {{HI_W{sgn_rel & b_i[NARROW_W-1]}}, b_i[NARROW_W-1:0]};
    end else begin
      a_x = a_i;
      b_x = b_i;
    end
    eq  = (a_x == b_x);
    lts = ($signed(a_x) < $signed(b_x));
    ltu = (a_x < b_x);
    unique case (rel_i)
      REL_EQ:  cmp_res = eq;
      REL_NE:  cmp_res = !eq;
      REL_LT:  cmp_res = lts;
      REL_LE:  cmp_res = lts | eq;
      REL_GT:  cmp_res = !(lts | eq);
      REL_GE:  cmp_res = !lts;
      REL_LTU: cmp_res = ltu;
      REL_LEU: cmp_res = ltu | eq;
      REL_GTU: cmp_res = !(ltu | eq);
      REL_GEU: cmp_res = !ltu;
      default: cmp_res = 1'b0;
    endcase
    unique case (op_i)
      OP_CMP:  res_o = cmp_res;
      OP_TBIT: res_o = a_i[bit_pos_i];
      OP_TNAT: res_o = nat_i;
      default: res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pred_type_decode.sv
module pred_type_decode
  import pred_cmp_pkg::*;
(
  input  logic       valid_i,
  input  logic [2:0] ctype_i,
  input  logic       qp_i,
  input  logic       res_i,
  output pwr_t       pw_o
);
  logic hit_t, hit_f;

  always_comb begin
    hit_t = qp_i & res_i;
    hit_f = qp_i & !res_i;
    pw_o  = '0;
    unique case (ctype_i)
      CT_NORM:     pw_o = '{we1: qp_i,  v1: res_i,    we2: qp_i,  v2: !res_i};
      CT_UNC:      pw_o = '{we1: 1'b1,  v1: hit_t,    we2: 1'b1,  v2: hit_f};
      CT_AND:      pw_o = '{we1: hit_f, v1: 1'b0,     we2: hit_f, v2: 1'b0};
      CT_ANDCM:    pw_o = '{we1: hit_t, v1: 1'b0,     we2: hit_t, v2: 1'b0};
      CT_OR:       pw_o = '{we1: hit_t, v1: 1'b1,     we2: hit_t, v2: 1'b1};
      CT_ORCM:     pw_o = '{we1: hit_f, v1: 1'b1,     we2: hit_f, v2: 1'b1};
      CT_OR_ANDCM: pw_o = '{we1: hit_t, v1: 1'b1,     we2: hit_t, v2: 1'b0};
      CT_AND_ORCM: pw_o = '{we1: hit_f, v1: 1'b0,     we2: hit_f, v2: 1'b1};
      default:     pw_o = '0;
    endcase
    if (!valid_i) pw_o = '0;
  end
endmodule

// File: rtl/pred_file.sv
module pred_file
  import pred_cmp_pkg::*;
#(
  parameter int NUM_PRED = 64,
  localparam int IDX_W   = $clog2(NUM_PRED)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  pwr_t                pw_i,
  input  logic [IDX_W-1:0]    t1_i,
  input  logic [IDX_W-1:0]    t2_i,
  output logic [NUM_PRED-1:0] pred_o
);
  logic [NUM_PRED-1:1] bits_q;

  for (genvar i = 1; i < NUM_PRED; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  bits_q[i] <= 1'b0;
      else if (pw_i.we1 && t1_i == IDX_W'(i))       bits_q[i] <= pw_i.v1;
      else if (pw_i.we2 && t2_i == IDX_W'(i))       bits_q[i] <= pw_i.v2;
    end
  end

  assign pred_o = {bits_q, 1'b1};
endmodule

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit
  import pred_cmp_pkg::*;
#(
  parameter int NUM_PRED = 64,
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  localparam int IDX_W   = $clog2(NUM_PRED),
  localparam int POS_W   = $clog2(DATA_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [1:0]          op_i,
  input  logic [3:0]          rel_i,
  input  logic                narrow_i,
  input  logic [2:0]          ctype_i,
  input  logic [DATA_W-1:0]   src_a_i,
  input  logic [DATA_W-1:0]   src_b_i,
  input  logic                use_imm_i,
  input  logic [DATA_W-1:0]   imm_i,
  input  logic [POS_W-1:0]    bit_pos_i,
  input  logic                nat_i,
  input  logic [IDX_W-1:0]    qp_idx_i,
  input  logic [IDX_W-1:0]    t1_idx_i,
  input  logic [IDX_W-1:0]    t2_idx_i,
  output logic [NUM_PRED-1:0] pred_o,
  output logic                conflict_o
);
  logic [DATA_W-1:0] b_sel;
  logic              res, qp_val, conflict_q;
  pwr_t              pw;

  assign b_sel  = use_imm_i ? imm_i : src_b_i;
  assign qp_val = pred_o[qp_idx_i];

  pred_cmp_eval #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_eval (
    .op_i(op_i), .rel_i(rel_i), .narrow_i(narrow_i),
    .a_i(src_a_i), .b_i(b_sel), .bit_pos_i(bit_pos_i), .nat_i(nat_i),
    .res_o(res)
  );

  pred_type_decode u_dec (
    .valid_i(valid_i), .ctype_i(ctype_i), .qp_i(qp_val), .res_i(res), .pw_o(pw)
  );

  pred_file #(.NUM_PRED(NUM_PRED)) u_file (
    .clk_i(clk_i), .rst_ni(rst_ni), .pw_i(pw),
    .t1_i(t1_idx_i), .t2_i(t2_idx_i), .pred_o(pred_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) conflict_q <= 1'b0;
    else         conflict_q <= pw.we1 & pw.we2 & (t1_idx_i == t2_idx_i);
  end

  assign conflict_o = conflict_q;
endmodule

// File: rtl/pred_cmp_chk.sv
module pred_cmp_chk #(
  parameter int NUM_PRED = 64,
  localparam int IDX_W   = $clog2(NUM_PRED)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [2:0]          ctype_i,
  input logic [IDX_W-1:0]    qp_idx_i,
  input logic [IDX_W-1:0]    t1_idx_i,
  input logic [IDX_W-1:0]    t2_idx_i,
  input logic [NUM_PRED-1:0] pred_o,
  input logic                conflict_o
);
  assert_p0_true_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_o[0]);

  assert_idle_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pred_o));

  assert_normal_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctype_i == 3'd0 && pred_o[qp_idx_i] && t1_idx_i != t2_idx_i &&
     t1_idx_i != '0 && t2_idx_i != '0)
    |=> pred_o[$past(t1_idx_i)] != pred_o[$past(t2_idx_i)]);

  assert_unc_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctype_i == 3'd1 && !pred_o[qp_idx_i] && t1_idx_i != '0)
    |=> !pred_o[$past(t1_idx_i)]);

  assert_and_never_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctype_i == 3'd2 && t1_idx_i != '0)
    |=> !(pred_o[$past(t1_idx_i)] && !$past(pred_o[t1_idx_i])));

  assert_conflict_flag_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctype_i == 3'd1 && t1_idx_i == t2_idx_i) |=> conflict_o);

  assert_conflict_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !conflict_o);
endmodule

bind pred_cmp_unit pred_cmp_chk #(.NUM_PRED(NUM_PRED)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .ctype_i(ctype_i),
  .qp_idx_i(qp_idx_i), .t1_idx_i(t1_idx_i), .t2_idx_i(t2_idx_i),
  .pred_o(pred_o), .conflict_o(conflict_o)
);

// File: tb/sim_pred_cmp_unit.sv
`timescale 1ns/1ps
module sim_pred_cmp_unit;
  typedef struct packed {
    logic [3:0]  rel;
    logic        nar;
    logic [63:0] a;
    logic [63:0] b;
    logic        exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 1'b0, 64'd5, 64'd5, 1'b1},
    '{4'd1, 1'b0, 64'd5, 64'd5, 1'b0},
    '{4'd2, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b1},
    '{4'd6, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0},
    '{4'd3, 1'b0, 64'd3, 64'd3, 1'b1},
    '{4'd4, 1'b0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1},
    '{4'd8, 1'b0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
    '{4'd5, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1},
    '{4'd9, 1'b0, 64'd0, 64'd1, 1'b0},
    '{4'd7, 1'b0, 64'd0, 64'd1, 1'b1},
    '{4'd0, 1'b1, 64'hAAAA_AAAA_0000_0007, 64'h5555_5555_0000_0007, 1'b1},
    '{4'd2, 1'b1, 64'h0000_0000_8000_0000, 64'd1, 1'b1},
    '{4'd6, 1'b1, 64'h0000_0000_8000_0000, 64'd1, 1'b0},
    '{4'd2, 1'b0, 64'h0000_0000_8000_0000, 64'd1, 1'b0},
    '{4'd8, 1'b1, 64'hFFFF_FFFF_0000_0001, 64'd2, 1'b0}
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0, valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [3:0]  rel_i = '0;
  logic        narrow_i = 1'b0;
  logic [2:0]  ctype_i = '0;
  logic [63:0] src_a_i = '0, src_b_i = '0, imm_i = '0;
  logic        use_imm_i = 1'b0, nat_i = 1'b0;
  logic [5:0]  bit_pos_i = '0, qp_idx_i = '0, t1_idx_i = '0, t2_idx_i = '0;
  logic [63:0] pred_o;
  logic        conflict_o;

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pred_cmp_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .rel_i(rel_i),
    .narrow_i(narrow_i), .ctype_i(ctype_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
    .use_imm_i(use_imm_i), .imm_i(imm_i), .bit_pos_i(bit_pos_i), .nat_i(nat_i),
    .qp_idx_i(qp_idx_i), .t1_idx_i(t1_idx_i), .t2_idx_i(t2_idx_i),
    .pred_o(pred_o), .conflict_o(conflict_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [3:0] rel, input logic nar,
                        input logic [2:0] ct, input logic [63:0] a, input logic [63:0] b,
                        input logic [5:0] qp, input logic [5:0] t1, input logic [5:0] t2);
    @(negedge clk_i);
    op_i = op; rel_i = rel; narrow_i = nar; ctype_i = ct; src_a_i = a; src_b_i = b;
    qp_idx_i = qp; t1_idx_i = t1; t2_idx_i = t2; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  // eq 0,0 under normal type: first target gets 1, second gets 0; p0 side is dropped
  task automatic set_p(input logic [5:0] idx, input logic val);
    if (val) run_op(2'd0, 4'd0, 1'b0, 3'd0, 64'd0, 64'd0, 6'd0, idx, 6'd0);
    else     run_op(2'd0, 4'd0, 1'b0, 3'd0, 64'd0, 64'd0, 6'd0, 6'd0, idx);
  endtask

  function automatic logic [63:0] pair(input logic x, input logic y);
    return {62'd0, y, x};
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset file", pred_o, 64'h1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset file", pred_o, 64'h1);
    chk("R1 reset conflict", {63'd0, conflict_o}, 64'd0);

    // R2 R3 R5 relation table, normal type, always-true qualifier
    for (int i = 0; i < NV; i++) begin
      run_op(2'd0, VECS[i].rel, VECS[i].nar, 3'd0, VECS[i].a, VECS[i].b, 6'd0, 6'd1, 6'd2);
      chk(VECS[i].nar ? "R3 narrow relation" : "R2 relation",
          pair(pred_o[1], pred_o[2]), pair(VECS[i].exp, !VECS[i].exp));
    end
    run_op(2'd0, 4'd12, 1'b0, 3'd0, 64'd5, 64'd5, 6'd0, 6'd1, 6'd2);
    chk("R2 unused relation code", pair(pred_o[1], pred_o[2]), pair(1'b0, 1'b1));

    // R4 immediate operand
    use_imm_i = 1'b1; imm_i = 64'd7;
    run_op(2'd0, 4'd0, 1'b0, 3'd0, 64'd7, 64'd99, 6'd0, 6'd1, 6'd2);
    chk("R4 immediate", pair(pred_o[1], pred_o[2]), pair(1'b1, 1'b0));
    use_imm_i = 1'b0;
    run_op(2'd0, 4'd0, 1'b0, 3'd0, 64'd7, 64'd99, 6'd0, 6'd1, 6'd2);
    chk("R4 register operand", pair(pred_o[1], pred_o[2]), pair(1'b0, 1'b1));

    // R5 normal, false qualifier leaves targets
    set_p(6'd10, 1'b0); set_p(6'd1, 1'b0); set_p(6'd2, 1'b1);
    run_op(2'd0, 4'd0, 1'b0, 3'd0, 64'd5, 64'd5, 6'd10, 6'd1, 6'd2);
    chk("R5 qp false", pair(pred_o[1], pred_o[2]), pair(1'b0, 1'b1));

    // R6 unconditional
    set_p(6'd3, 1'b1); set_p(6'd4, 1'b1);
    run_op(2'd0, 4'd0, 1'b0, 3'd1, 64'd5, 64'd5, 6'd10, 6'd3, 6'd4);
    chk("R6 unc qp false", pair(pred_o[3], pred_o[4]), pair(1'b0, 1'b0));
    run_op(2'd0, 4'd0, 1'b0, 3'd1, 64'd1, 64'd2, 6'd0, 6'd3, 6'd4);
    chk("R6 unc qp true", pair(pred_o[3], pred_o[4]), pair(1'b0, 1'b1));

    // R7 and / andcm
    set_p(6'd5, 1'b1); set_p(6'd6, 1'b1);
    run_op(2'd0, 4'd0, 1'b0, 3'd2, 64'd1, 64'd1, 6'd0, 6'd5, 6'd6);
    chk("R7 and true holds", pair(pred_o[5], pred_o[6]), pair(1'b1, 1'b1));
    run_op(2'd0, 4'd0, 1'b0, 3'd2, 64'd1, 64'd2, 6'd10, 6'd5, 6'd6);
    chk("R7 and qp false holds", pair(pred_o[5], pred_o[6]), pair(1'b1, 1'b1));
    run_op(2'd0, 4'd0, 1'b0, 3'd2, 64'd1, 64'd2, 6'd0, 6'd5, 6'd6);
    chk("R7 and false clears", pair(pred_o[5], pred_o[6]), pair(1'b0, 1'b0));
    set_p(6'd5, 1'b1); set_p(6'd6, 1'b1);
    run_op(2'd0, 4'd0, 1'b0, 3'd3, 64'd1, 64'd2, 6'd0, 6'd5, 6'd6);
    chk("R7 andcm false holds", pair(pred_o[5], pred_o[6]), pair(1'b1, 1'b1));
    run_op(2'd0, 4'd0, 1'b0, 3'd3, 64'd1, 64'd1, 6'd0, 6'd5, 6'd6);
    chk("R7 andcm true clears", pair(pred_o[5], pred_o[6]), pair(1'b0, 1'b0));

    // R8 or / orcm
    run_op(2'd0, 4'd0, 1'b0, 3'd4, 64'd1, 64'd2, 6'd0, 6'd5, 6'd6);
    chk("R8 or false holds", pair(pred_o[5], pred_o[6]), pair(1'b0, 1'b0));
    run_op(2'd0, 4'd0, 1'b0, 3'd4, 64'd1, 64'd1, 6'd0, 6'd5, 6'd6);
    chk("R8 or true sets", pair(pred_o[5], pred_o[6]), pair(1'b1, 1'b1));
    set_p(6'd5, 1'b0); set_p(6'd6, 1'b0);
    run_op(2'd0, 4'd0, 1'b0, 3'd5, 64'd1, 64'd1, 6'd0, 6'd5, 6'd6);
    chk("R8 orcm true holds", pair(pred_o[5], pred_o[6]), pair(1'b0, 1'b0));
    run_op(2'd0, 4'd0, 1'b0, 3'd5, 64'd1, 64'd2, 6'd0, 6'd5, 6'd6);
    chk("R8 orcm false sets", pair(pred_o[5], pred_o[6]), pair(1'b1, 1'b1));

    // R9 mixed types
    set_p(6'd7, 1'b0); set_p(6'd8, 1'b1);
    run_op(2'd0, 4'd0, 1'b0, 3'd6, 64'd1, 64'd2, 6'd0, 6'd7, 6'd8);
    chk("R9 or.andcm false holds", pair(pred_o[7], pred_o[8]), pair(1'b0, 1'b1));
    run_op(2'd0, 4'd0, 1'b0, 3'd6, 64'd1, 64'd1, 6'd0, 6'd7, 6'd8);
    chk("R9 or.andcm true", pair(pred_o[7], pred_o[8]), pair(1'b1, 1'b0));
    run_op(2'd0, 4'd0, 1'b0, 3'd7, 64'd1, 64'd1, 6'd0, 6'd7, 6'd8);
    chk("R9 and.orcm true holds", pair(pred_o[7], pred_o[8]), pair(1'b1, 1'b0));
    run_op(2'd0, 4'd0, 1'b0, 3'd7, 64'd1, 64'd2, 6'd0, 6'd7, 6'd8);
    chk("R9 and.orcm false", pair(pred_o[7], pred_o[8]), pair(1'b0, 1'b1));

    // R10 bit and flag probes
    bit_pos_i = 6'd45;
    run_op(2'd1, 4'd0, 1'b0, 3'd0, 64'd1 << 45, 64'd0, 6'd0, 6'd11, 6'd12);
    chk("R10 bit set", pair(pred_o[11], pred_o[12]), pair(1'b1, 1'b0));
    bit_pos_i = 6'd44;
    run_op(2'd1, 4'd0, 1'b0, 3'd0, 64'd1 << 45, 64'd0, 6'd0, 6'd11, 6'd12);
    chk("R10 bit clear", pair(pred_o[11], pred_o[12]), pair(1'b0, 1'b1));
    nat_i = 1'b1;
    run_op(2'd2, 4'd0, 1'b0, 3'd0, 64'd3, 64'd4, 6'd0, 6'd11, 6'd12);
    chk("R10 flag set", pair(pred_o[11], pred_o[12]), pair(1'b1, 1'b0));
    nat_i = 1'b0;
    run_op(2'd2, 4'd0, 1'b0, 3'd0, 64'd3, 64'd3, 6'd0, 6'd11, 6'd12);
    chk("R10 flag clear", pair(pred_o[11], pred_o[12]), pair(1'b0, 1'b1));

    // R11 entry 0 cannot be cleared
    run_op(2'd0, 4'd0, 1'b0, 3'd1, 64'd1, 64'd2, 6'd0, 6'd0, 6'd13);
    chk("R11 p0 stays 1", {63'd0, pred_o[0]}, 64'd1);
    chk("R11 other target", {63'd0, pred_o[13]}, 64'd1);

    // R12 same target for both
    run_op(2'd0, 4'd0, 1'b0, 3'd1, 64'd1, 64'd1, 6'd0, 6'd14, 6'd14);
    chk("R12 first wins", {63'd0, pred_o[14]}, 64'd1);
    chk("R12 conflict set", {63'd0, conflict_o}, 64'd1);
    @(negedge clk_i);
    chk("R12 conflict drops", {63'd0, conflict_o}, 64'd0);
    run_op(2'd0, 4'd0, 1'b0, 3'd1, 64'd1, 64'd2, 6'd0, 6'd14, 6'd14);
    chk("R12 first wins false", {63'd0, pred_o[14]}, 64'd0);

    // R13 no strobe no change; update lands only at the edge
    begin
      logic [63:0] snap;
      snap = pred_o;
      @(negedge clk_i);
      op_i = 2'd0; rel_i = 4'd0; ctype_i = 3'd1; src_a_i = 64'd1; src_b_i = 64'd1;
      qp_idx_i = 6'd0; t1_idx_i = 6'd20; t2_idx_i = 6'd7;
      repeat (2) @(negedge clk_i);
      chk("R13 idle holds", pred_o, snap);
      valid_i = 1'b1;
      #1;
      chk("R13 not before edge", {63'd0, pred_o[20]}, 64'd0);
      @(negedge clk_i);
      valid_i = 1'b0;
      chk("R13 after edge", pair(pred_o[20], pred_o[7]), pair(1'b1, 1'b0));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule